// File: doc/BRIEF.md
# Peripheral Event Flags with Write-Zero Clear

This block keeps the pending-event flags of a peripheral that has several internal event sources, for example a timer that reports capture, compare and overflow on separate lines. Each source pulses its own event input. The pulse sets a sticky flag bit, and the bit stays set until software clears it. A mask register of the same width picks which flags may raise the single interrupt request that goes to the CPU interrupt controller.

Software reaches both registers through one write port with a register select. The mask register is a plain read/write register. The flag register clears only those bits written as 0, and bits written as 1 are left alone. A driver can therefore clear one flag by writing a word that is all ones except for that bit. Writing ones to the flag register never discards an event that arrived since the last read. Both registers are shown in full on output ports, which act as the read path.

The width is a parameter, and so is the set of bit positions that have an event source. A bit with no source is held at 0. The design has no state machine: every flag bit updates on its own in each cycle.

Top module: `evt_irq_flags`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every flag bit and every mask bit reads 0 and the interrupt request is low.
- R2: A high event input on a bit that has a source sets that flag at the next rising edge. The flag then stays set through any number of idle cycles.
- R3: A write to the flag register (select = 0) clears every implemented flag whose data bit is 0. Data bits that are 1 have no effect, so writing all ones leaves every flag as it was.
- R4: Writing a word with only bit k at 0 clears flag k and leaves every other flag unchanged.
- R5: When an event arrives in the same cycle as a write of 0 to its flag bit, the event wins and the flag is set after the edge.
- R6: A write with select = 1 loads the mask register, and the new value appears at the next rising edge.
- R7: The interrupt request is high exactly when some flag and its mask bit are both set. It follows a change of the flag or mask state in the same cycle, with no extra register.
- R8: Setting a mask bit creates no flag. A flag that is already set raises the request in the cycle right after its mask bit is written to 1.
- R9: Bit positions without an event source (the default width is 8 bits, with sources on bits 0 to 5) read 0 in both registers. Events and writes on those positions are ignored.
- R10: A write to the flag register leaves the mask unchanged, and a write to the mask register leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One event strobe per flag bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects the flag register, 1 selects the mask register |
| wr_data_i | input | 8 | Write data |
| flag_o | output | 8 | Current flag register |
| mask_o | output | 8 | Current mask register |
| irq_o | output | 1 | Interrupt request to the CPU controller |

## Verification
An event or a write is registered at the rising edge where it is seen, so the flag and mask ports change one edge after the stimulus. The request is combinational from those registers and changes in that same cycle. The bench applies each stimulus after a falling edge and advances its own model at the next rising edge. At the falling edge that follows, it compares all three outputs with the model, so every clock is checked once at a settled point.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    typedef enum logic {
        SEL_FLAG = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
    parameter int              W         = 8,
    parameter logic [W-1:0]    IMPL_BITS = 8'h3F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] flag_q
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W-1:0] flag_d;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL_BITS[i]) begin : g_live
            logic zero_hit;
            assign zero_hit  = clr_wr & ~clr_data[i];
            assign flag_d[i] = evt[i] | (flag_q[i] & ~zero_hit);
        end else begin : g_dead
            assign flag_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assert_ones_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data == ALL_ONES) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    assert_zero_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((flag_q & $past(~clr_data & ~evt)) == '0));

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flag_q & $past(evt & IMPL_BITS)) == $past(evt & IMPL_BITS)));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && evt == '0) |=> $stable(flag_q));

endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
    parameter int              W         = 8,
    parameter logic [W-1:0]    IMPL_BITS = 8'h3F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mask_q <= '0;
        else if (load) mask_q <= load_data & IMPL_BITS;
    end

    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mask_q));

endmodule

// File: rtl/evt_req_merge.sv
module evt_req_merge #(
    parameter int W = 8
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] mask,
    output logic         req
);

    assign req = |(flags & mask);

endmodule

// File: rtl/evt_irq_flags.sv
module evt_irq_flags
    import evt_irq_pkg::*;
#(
    parameter int              W         = 8,
    parameter logic [W-1:0]    IMPL_BITS = 8'h3F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         wr_en_i,
    input  logic         wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] flag_o,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);

    reg_sel_e sel;
    logic     flag_wr;
    logic     mask_wr;

    assign sel     = reg_sel_e'(wr_sel_i);
    assign flag_wr = wr_en_i && (sel == SEL_FLAG);
    assign mask_wr = wr_en_i && (sel == SEL_MASK);

    evt_flag_bank #(.W(W), .IMPL_BITS(IMPL_BITS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_i),
        .clr_wr   (flag_wr),
        .clr_data (wr_data_i),
        .flag_q   (flag_o)
    );

    evt_mask_bank #(.W(W), .IMPL_BITS(IMPL_BITS)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (mask_wr),
        .load_data (wr_data_i),
        .mask_q    (mask_o)
    );

    evt_req_merge #(.W(W)) u_merge (
        .flags (flag_o),
        .mask  (mask_o),
        .req   (irq_o)
    );

    assert_mask_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && evt_i == '0) |=> $stable(flag_o));

    assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_o | mask_o) & ~IMPL_BITS) == '0);

    assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |-> !irq_o);

endmodule

// File: tb/evt_irq_flags_tb_top.sv
`timescale 1ns/1ps
module evt_irq_flags_tb_top;

    localparam logic [7:0] IMPL = 8'h3F;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] evt_i;
    logic       wr_en_i;
    logic       wr_sel_i;
    logic [7:0] wr_data_i;
    logic [7:0] flag_o;
    logic [7:0] mask_o;
    logic       irq_o;

    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] m_flag;
    logic [7:0] m_mask;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    evt_irq_flags dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .flag_o(flag_o), .mask_o(mask_o), .irq_o(irq_o)
    );

    task automatic compare(input string tag);
        logic m_irq;
        m_irq = |(m_flag & m_mask);
        n_cmp++;
        if (flag_o !== m_flag || mask_o !== m_mask || irq_o !== m_irq) begin
            n_bad++;
            $display("FAIL %s: flag=%h mask=%h irq=%b expected flag=%h mask=%h irq=%b",
                     tag, flag_o, mask_o, irq_o, m_flag, m_mask, m_irq);
        end
    endtask

    // called at a falling edge: drive, model the rising edge, compare at next falling edge
    task automatic step(input logic [7:0] e, input logic we, input logic sel,
                        input logic [7:0] d, input string tag);
        evt_i = e; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
        @(posedge clk);
        m_flag = ((m_flag & ((we && !sel) ? d : 8'hFF)) | e) & IMPL;
        if (we && sel) m_mask = d & IMPL;
        @(negedge clk);
        evt_i = '0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        evt_i = '0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
        m_flag = '0; m_mask = '0;
        @(negedge clk);
        compare(tag);
        rst_n = 1'b1;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        rst_n = 1'b0;
        evt_i = '0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
        m_flag = '0; m_mask = '0;
        repeat (2) @(negedge clk);
        do_reset("R1 reset state");

        step(8'h05, 0, 0, 8'h00, "R2 event sets flags 0,2");
        for (int i = 0; i < 4; i++) step(8'h00, 0, 0, 8'h00, "R2 flags stay sticky");
        step(8'hC0, 0, 0, 8'h00, "R9 events on unimplemented bits ignored");
        step(8'h00, 1, 1, 8'h01, "R8 mask bit 0 raises irq from held flag");
        step(8'h00, 1, 1, 8'h02, "R7 mask on clear flag gives no irq");
        step(8'h00, 1, 1, 8'hC2, "R9 mask write to unimplemented bits ignored");
        step(8'h00, 1, 0, 8'hFF, "R3 all-ones write clears nothing");
        step(8'h00, 1, 0, 8'hFB, "R3 zero bit 2 clears flag 2");
        step(8'h3F, 0, 0, 8'h00, "R2 all sources fire");
        step(8'h00, 1, 0, 8'hF7, "R4 clear only flag 3");
        step(8'h00, 1, 0, 8'hFE, "R4 clear only flag 0");
        step(8'h10, 1, 0, 8'h00, "R5 event beats clear on bit 4");
        step(8'h00, 1, 1, 8'hFF, "R6 mask loads all implemented bits");
        step(8'h00, 1, 1, 8'h00, "R10 mask write leaves flags");
        step(8'h22, 1, 1, 8'h20, "R8 mask with simultaneous event");
        step(8'h00, 1, 0, 8'hDF, "R10 flag clear leaves mask");
        step(8'h00, 1, 1, 8'h00, "R7 irq drops with mask");
        for (int i = 0; i < 300; i++)
            step(8'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), "R7 mixed traffic");
        step(8'h3F, 1, 1, 8'h3F, "R2 load before reset");
        do_reset("R1 reset mid-run");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule